// File: doc/BRIEF.md
# Quiesce Handshake Power Controller

This controller sits on the processor side of a low-power handshake with the system bus arbiter. Software selects a power mode by pulsing a request strobe with a 2-bit code. The block then steps a mode machine through run, doze, nap and sleep. Doze keeps bus snooping alive. Nap and sleep are quiescent states. To enter either one, the block raises a quiesce request and waits for the arbiter to acknowledge that all snoopable traffic has stopped.

While the block is quiescent it reports that the core clocks may be stopped, and it holds snoop-enable low. If the arbiter withdraws its acknowledge, the block falls back to doze and keeps the request raised, so it can re-enter the deep mode once the acknowledge returns. Every exit from a quiescent state starts a short recovery window. Snoop-enable comes back at a fixed number of cycles after the exit, well inside the eight-cycle window the arbiter leaves before its next snoop. A wake pulse returns the block to run from any low-power state.

All pins are plain control and status signals. No data stream crosses the block's edge, so it has no valid/ready pairs.

Top module: `quiesce_pwr_ctrl`

## Requirements
- R1: After reset the mode output is run (00), quiesce_req is low, snoop_en is high and clk_stop_ok is low.
- R2: A strobe with code 01 (doze) from run moves the mode to doze (01) on the next cycle. quiesce_req stays low and snoop_en stays high.
- R3: A strobe with code 10 (nap) or 11 (sleep) from run or doze gives mode doze with quiesce_req high on the next cycle. The block stays in doze while quiesce_ack is low.
- R4: In doze with a nap or sleep target, quiesce_ack high while quiesce_req is high moves the mode to the target on the next cycle. clk_stop_ok then rises and snoop_en falls.
- R5: quiesce_ack has no effect while quiesce_req is low. The block stays in run or in doze.
- R6: In nap (10) and sleep (11), quiesce_req stays high and snoop_en stays low.
- R7: quiesce_ack low in nap or sleep returns the mode to doze on the next cycle, with quiesce_req still high. A later acknowledge re-enters the same deep mode.
- R8: After any exit from nap or sleep, snoop_en stays low for RECOV_CYC cycles and is high in the next cycle (the fourth one with the default of 3). This is never later than the eighth cycle.
- R9: wake in doze, nap or sleep gives mode run with quiesce_req low on the next cycle. wake takes priority over a same-cycle acknowledge drop.
- R10: Mode strobes are ignored in nap and sleep. In doze, code 00 returns to run and another code retargets; retargeting to doze drops quiesce_req.
- R11: A strobe with code 00 in run, and wake in run, leave the block unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_stb | input | 1 | One-cycle mode request strobe |
| mode_sel | input | 2 | Requested mode: 00 run, 01 doze, 10 nap, 11 sleep |
| wake | input | 1 | Return to run |
| quiesce_ack | input | 1 | Arbiter acknowledge: snoopable traffic stopped |
| quiesce_req | output | 1 | Request for the bus to go quiet |
| snoop_en | output | 1 | Snooping allowed |
| clk_stop_ok | output | 1 | Core clocks may be stopped (nap or sleep) |
| pmode | output | 2 | Current mode, same encoding as mode_sel |

## Verification
The directed corner cases cover three groups. First, acknowledges arriving with the request low and with it high, which separates a gated handshake from a bare one. Second, acknowledge drops from nap and from sleep with the recovery window counted cycle by cycle, which checks the exact snoop-enable return time. Third, wake arriving together with an acknowledge drop, which checks the priority between them. Retarget and ignored strobes in doze, nap and sleep show whether requests are filtered by state. A seeded random phase then applies strobes, wake and a toggling acknowledge against a cycle model, which exposes ordering faults between simultaneous inputs.

// File: rtl/qh_pkg.sv
package qh_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'b00,
    PM_DOZE  = 2'b01,
    PM_NAP   = 2'b10,
    PM_SLEEP = 2'b11
  } pmode_e;
endpackage

// File: rtl/qh_mode_fsm.sv
module qh_mode_fsm
  import qh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_stb,
  input  logic [1:0] mode_sel,
  input  logic       wake,
  input  logic       quiesce_ack,
  output pmode_e     mode,
  output logic       quiesce_req,
  output logic       quiet,
  output logic       leave_quiet
);
  pmode_e state_q, state_d;
  pmode_e target_q, target_d;
  logic   ack_ok;

  // the acknowledge counts only while the request is raised
  assign quiesce_req = (state_q != PM_RUN) && target_q[1];
  assign ack_ok      = quiesce_ack && quiesce_req;
  assign quiet       = (state_q == PM_NAP) || (state_q == PM_SLEEP);
  assign leave_quiet = quiet && !((state_d == PM_NAP) || (state_d == PM_SLEEP));
  assign mode        = state_q;

  always_comb begin
    state_d  = state_q;
    target_d = target_q;
    unique case (state_q)
      PM_RUN: begin
        if (mode_stb && mode_sel != 2'b00) begin
          state_d  = PM_DOZE;
          target_d = pmode_e'(mode_sel);
        end
      end
      PM_DOZE: begin
        if (wake) begin
          state_d  = PM_RUN;
          target_d = PM_RUN;
        end else if (mode_stb) begin
          target_d = pmode_e'(mode_sel);
          if (mode_sel == 2'b00) state_d = PM_RUN;
        end else if (target_q[1] && ack_ok) begin
          state_d = target_q;
        end
      end
      default: begin
        if (wake) begin
          state_d  = PM_RUN;
          target_d = PM_RUN;
        end else if (!quiesce_ack) begin
          state_d = PM_DOZE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PM_RUN;
      target_q <= PM_RUN;
    end else begin
      state_q  <= state_d;
      target_q <= target_d;
    end
  end

  assert_qreq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> quiesce_req);
  assert_entry_needs_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!quiet && state_d != PM_RUN && state_d != PM_DOZE) |-> (quiesce_req && quiesce_ack));
  assert_ack_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !quiesce_ack && !wake) |=> (state_q == PM_DOZE && quiesce_req));
  assert_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && state_q != PM_RUN) |=> (state_q == PM_RUN && !quiesce_req));
  assert_run_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_RUN && !(mode_stb && mode_sel != 2'b00)) |=> state_q == PM_RUN);
endmodule

// File: rtl/qh_snoop_recovery.sv
module qh_snoop_recovery #(
  parameter int RECOV_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic quiet,
  input  logic leave_quiet,
  output logic snoop_en
);
  localparam int CW = $clog2(RECOV_CYC + 2);
  localparam logic [CW-1:0] LOAD = CW'(RECOV_CYC);

  logic [CW-1:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              wait_q <= '0;
    else if (leave_quiet)    wait_q <= LOAD;
    else if (wait_q != '0)   wait_q <= wait_q - 1'b1;
  end

  assign snoop_en = !quiet && (wait_q == '0);

  // count cycles with snooping held off outside a quiescent state
  logic [3:0] low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        low_run_q <= '0;
    else if (snoop_en || quiet)        low_run_q <= '0;
    else if (low_run_q != 4'hF)        low_run_q <= low_run_q + 1'b1;
  end

  assert_snoop_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    low_run_q < 4'd7);
  assert_snoop_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> !snoop_en);
endmodule

// File: rtl/quiesce_pwr_ctrl.sv
module quiesce_pwr_ctrl
  import qh_pkg::*;
#(
  parameter int RECOV_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_stb,
  input  logic [1:0] mode_sel,
  input  logic       wake,
  input  logic       quiesce_ack,
  output logic       quiesce_req,
  output logic       snoop_en,
  output logic       clk_stop_ok,
  output logic [1:0] pmode
);
  pmode_e mode;
  logic   quiet, leave_quiet;

  qh_mode_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_stb    (mode_stb),
    .mode_sel    (mode_sel),
    .wake        (wake),
    .quiesce_ack (quiesce_ack),
    .mode        (mode),
    .quiesce_req (quiesce_req),
    .quiet       (quiet),
    .leave_quiet (leave_quiet)
  );

  qh_snoop_recovery #(.RECOV_CYC(RECOV_CYC)) u_recov (
    .clk         (clk),
    .rst_n       (rst_n),
    .quiet       (quiet),
    .leave_quiet (leave_quiet),
    .snoop_en    (snoop_en)
  );

  assign clk_stop_ok = quiet;
  assign pmode       = mode;

  assert_ignore_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!quiesce_req && pmode == 2'b01 && !mode_stb && !wake) |=> pmode == 2'b01);
  assert_quiet_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_stop_ok && quiesce_ack && !wake) |=> $stable(pmode));
endmodule

// File: tb/quiesce_pwr_ctrl_test.sv
module quiesce_pwr_ctrl_test;
  localparam int RC = 3;
  logic clk = 0, rst_n = 0;
  logic mode_stb = 0, wake = 0, quiesce_ack = 0;
  logic [1:0] mode_sel = 0;
  logic quiesce_req, snoop_en, clk_stop_ok;
  logic [1:0] pmode;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  quiesce_pwr_ctrl #(.RECOV_CYC(RC)) uut (
    .clk(clk), .rst_n(rst_n), .mode_stb(mode_stb), .mode_sel(mode_sel),
    .wake(wake), .quiesce_ack(quiesce_ack), .quiesce_req(quiesce_req),
    .snoop_en(snoop_en), .clk_stop_ok(clk_stop_ok), .pmode(pmode));

  // cycle model built from the requirements
  logic [1:0] m_st = 0, m_tg = 0;
  int m_cnt = 0;
  function automatic logic m_qreq(); return (m_st != 0) && m_tg[1]; endfunction
  function automatic logic m_deep(logic [1:0] s); return s[1]; endfunction
  function automatic logic m_snoop(); return !m_deep(m_st) && m_cnt == 0; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_st = 0; m_tg = 0; m_cnt = 0; end
    else begin
      logic [1:0] ns, nt;
      ns = m_st; nt = m_tg;
      if (m_st == 0) begin
        if (mode_stb && mode_sel != 0) begin ns = 1; nt = mode_sel; end
      end else if (m_st == 1) begin
        if (wake) begin ns = 0; nt = 0; end
        else if (mode_stb) begin nt = mode_sel; if (mode_sel == 0) ns = 0; end
        else if (m_tg[1] && quiesce_ack) ns = m_tg;
      end else begin
        if (wake) begin ns = 0; nt = 0; end
        else if (!quiesce_ack) ns = 1;
      end
      if (m_deep(m_st) && !m_deep(ns)) m_cnt = RC;
      else if (m_cnt != 0) m_cnt = m_cnt - 1;
      m_st = ns; m_tg = nt;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic strobe(logic [1:0] s);
    mode_stb = 1; mode_sel = s; step(); mode_stb = 0;
  endtask

  task automatic outs(string tag, int pm, int qr, int sn, int cs);
    chk(tag, "pmode", pmode, pm);
    chk(tag, "quiesce_req", quiesce_req, qr);
    chk(tag, "snoop_en", snoop_en, sn);
    chk(tag, "clk_stop_ok", clk_stop_ok, cs);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    outs("R1", 0, 0, 1, 0);
    rst_n = 1; step();
    outs("R1", 0, 0, 1, 0);
    quiesce_ack = 1; step(2);
    outs("R5", 0, 0, 1, 0);
    wake = 1; step(); wake = 0;
    strobe(2'b00);
    outs("R11", 0, 0, 1, 0);
    strobe(2'b01);
    outs("R2", 1, 0, 1, 0);
    step(3);
    outs("R5", 1, 0, 1, 0);
    quiesce_ack = 0;
    strobe(2'b10);
    outs("R3", 1, 1, 1, 0);
    step(2);
    outs("R3", 1, 1, 1, 0);
    quiesce_ack = 1; step();
    outs("R4", 2, 1, 0, 1);
    step(3);
    outs("R6", 2, 1, 0, 1);
    strobe(2'b01);
    outs("R10", 2, 1, 0, 1);
    quiesce_ack = 0; step();
    outs("R7", 1, 1, 0, 0);
    step(2);
    chk("R8", "snoop_en third cycle", snoop_en, 0);
    step();
    chk("R8", "snoop_en fourth cycle", snoop_en, 1);
    quiesce_ack = 1; step();
    outs("R7", 2, 1, 0, 1);
    quiesce_ack = 0; wake = 1; step(); wake = 0;
    outs("R9", 0, 0, 0, 0);
    step(3);
    chk("R8", "snoop_en after wake", snoop_en, 1);
    strobe(2'b11);
    outs("R3", 1, 1, 1, 0);
    quiesce_ack = 1; step();
    outs("R4", 3, 1, 0, 1);
    quiesce_ack = 0; step();
    outs("R7", 1, 1, 0, 0);
    quiesce_ack = 1; step();
    outs("R7", 3, 1, 0, 1);
    strobe(2'b00);
    outs("R10", 3, 1, 0, 1);
    wake = 1; step(); wake = 0;
    outs("R9", 0, 0, 0, 0);
    quiesce_ack = 0; step(4);
    strobe(2'b10);
    strobe(2'b01);
    outs("R10", 1, 0, 1, 0);
    quiesce_ack = 1; step(2);
    outs("R5", 1, 0, 1, 0);
    strobe(2'b00);
    outs("R10", 0, 0, 1, 0);
    // random phase against the cycle model
    quiesce_ack = 0; rst_n = 0; step(2); rst_n = 1;
    for (int i = 0; i < 4000; i++) begin
      mode_stb = ($urandom % 6) == 0;
      mode_sel = 2'($urandom);
      wake = ($urandom % 25) == 0;
      if (($urandom % 5) == 0) quiesce_ack = ~quiesce_ack;
      step();
      outs("R4 R7 R9 random", m_st, m_qreq(), m_snoop(), m_deep(m_st));
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule